// File: doc/BRIEF.md
# NAND Read/Write Strobe Timing Generator

This block produces the read-enable and write-enable strobes for an asynchronous single-data-rate NAND data bus. Every timing figure is set in bus-clock cycles by configuration inputs: how long a strobe is held low, how long it then stays high, how many cycles after the read strobe falls the incoming bus is sampled, and how many idle cycles must separate the end of a read strobe from the start of a write strobe. A controller raises a request with a direction and, for writes, a data word. The block then runs one data cycle and reports the captured read word with a single-cycle valid pulse.

The sampling point is counted from the falling edge of the read strobe on its own timer. It can therefore land after the strobe has gone high again, inside the window in which the device still holds its output, or even after the next read strobe has fallen. Sampling instants still pending are kept in a shift mask, so overlapping reads each get their own capture. The configuration is expected to stay constant while the block is busy and while a capture is pending.

Top module: `nand_strobe_gen`

## Requirements
- R1: A request is taken at a rising clock edge only when `busy` is low at that edge. A request presented while `busy` is high has no effect, and every strobe fall belongs to exactly one accepted request of the matching direction (read lowers `reN`, write lowers `weN`).
- R2: The active strobe stays low for exactly the effective low count, in cycles, starting at the edge at which the request is accepted. `reN` and `weN` are never low together.
- R3: After the low time the strobe stays high for the effective high count. `busy` is low in the last high cycle, so requests held back to back start strobe falls exactly low+high cycles apart.
- R4: For a read whose strobe falls at edge k, `dqIn` is sampled at edge k+acc, and `rdData` shows that word with `rdValid` high for exactly one cycle after that edge. This holds when acc exceeds the low time and when it exceeds a full cycle.
- R5: A write that follows a read lowers `weN` no sooner than the effective turnaround count of cycles after `reN` rose. When the read's high time is already at least the turnaround count, no extra cycle is added. Otherwise `weN` falls exactly turnaround cycles after the rise.
- R6: A configuration value above 15 (the maximum of the 4-bit internal count) acts as 15.
- R7: A configuration value of zero acts as 1.
- R8: For a write, `dqOut` carries the request's data word and `dqOe` is high from the `weN` fall to the end of the cycle. `dqOe` is low when idle.
- R9: After reset `reN` and `weN` are high, and `busy`, `rdValid` and `dqOe` are low.
- R10: Write cycles produce no `rdValid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request a data cycle |
| reqWrite | input | 1 | 1 = write cycle, 0 = read cycle |
| reqWdata | input | DATA_W | Word to drive on a write |
| cfgLo | input | CFG_W | Strobe low time in cycles |
| cfgHi | input | CFG_W | Strobe high time in cycles |
| cfgAcc | input | CFG_W | Read sampling delay from the read strobe fall |
| cfgTurn | input | CFG_W | Minimum read-rise to write-fall gap |
| dqIn | input | DATA_W | Data bus from the device |
| busy | output | 1 | High while a new request cannot be taken |
| reN | output | 1 | Read strobe, active low |
| weN | output | 1 | Write strobe, active low |
| dqOut | output | DATA_W | Data bus toward the device |
| dqOe | output | 1 | Output enable for dqOut |
| rdData | output | DATA_W | Captured read word |
| rdValid | output | 1 | One-cycle pulse marking rdData |

## Verification
A wrong phase counter appears at once as a strobe low or high time that does not match the configuration, or as a fall-to-fall period that is off by a cycle, within one data cycle. A sampling mask that is lost or misaligned shows up acc cycles after the read fall as a wrong captured word. The bench drives `dqIn` with the running edge count, so the word itself names the edge at which it was sampled. A stale turnaround state shows as a write strobe falling too early or too late after the next read, and a stuck `busy` shows as missing or extra strobe falls in the following cycle.

// File: rtl/nand_strobe_pkg.sv
package nand_strobe_pkg;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_TURN = 2'd1,
    S_LOW  = 2'd2,
    S_HIGH = 2'd3
  } phase_e;

  // strobes from control to datapath, all single-cycle
  typedef struct packed {
    logic loadWr;    // latch the write word
    logic fallRd;    // drive read strobe low, arm a capture
    logic fallWr;    // drive write strobe low, enable bus
    logic rise;      // return the active strobe high
    logic endCycle;  // last high cycle done, release bus
  } strobe_t;

endpackage

// File: rtl/nand_cnt_clamp.sv
module nand_cnt_clamp #(
  parameter int IN_W  = 6,
  parameter int OUT_W = 4
) (
  input  logic [IN_W-1:0]  raw,
  output logic [OUT_W-1:0] eff
);
  localparam int LIMIT = (1 << OUT_W) - 1;

  always_comb begin
    if (raw == '0)
      eff = OUT_W'(1);
    else if (raw > IN_W'(LIMIT))
      eff = OUT_W'(LIMIT);
    else
      eff = raw[OUT_W-1:0];
  end
endmodule

// File: rtl/nand_strobe_ctrl.sv
module nand_strobe_ctrl
  import nand_strobe_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [CNT_W-1:0] loCnt,
  input  logic [CNT_W-1:0] hiCnt,
  input  logic [CNT_W-1:0] turnCnt,
  output logic             busy,
  output strobe_t          ss
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  phase_e           state, stateN;
  logic [CNT_W-1:0] cnt, cntN;
  logic [CNT_W-1:0] gapCnt;
  logic             isWr, isWrN;
  logic             lastRead;
  logic             lastHigh, accept, turnOk;

  assign lastHigh = (state == S_HIGH) && (cnt == hiCnt - ONE);
  assign busy     = !((state == S_IDLE) || lastHigh);
  assign accept   = reqValid && !busy;
  // enough high cycles since the last read strobe rose
  assign turnOk   = !lastRead || (gapCnt >= turnCnt - ONE);

  always_comb begin
    ss     = '0;
    stateN = state;
    cntN   = cnt;
    isWrN  = isWr;
    unique case (state)
      S_LOW: begin
        if (cnt == loCnt - ONE) begin
          stateN  = S_HIGH;
          cntN    = '0;
          ss.rise = 1'b1;
        end else begin
          cntN = cnt + ONE;
        end
      end
      S_HIGH: begin
        if (lastHigh) begin
          stateN      = S_IDLE;
          cntN        = '0;
          ss.endCycle = 1'b1;
        end else begin
          cntN = cnt + ONE;
        end
      end
      S_TURN: begin
        if (turnOk) begin
          stateN    = S_LOW;
          cntN      = '0;
          ss.fallWr = 1'b1;
        end
      end
      default: ;
    endcase
    if (accept) begin
      isWrN     = reqWrite;
      cntN      = '0;
      ss.loadWr = reqWrite;
      if (!reqWrite) begin
        stateN    = S_LOW;
        ss.fallRd = 1'b1;
      end else if (turnOk) begin
        stateN    = S_LOW;
        ss.fallWr = 1'b1;
      end else begin
        stateN = S_TURN;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      cnt      <= '0;
      isWr     <= 1'b0;
      lastRead <= 1'b0;
      gapCnt   <= CNT_MAX;
    end else begin
      state <= stateN;
      cnt   <= cntN;
      isWr  <= isWrN;
      if (ss.rise && !isWr) begin
        gapCnt   <= '0;
        lastRead <= 1'b1;
      end else begin
        if (gapCnt != CNT_MAX) gapCnt <= gapCnt + ONE;
        if (ss.fallWr) lastRead <= 1'b0;
      end
    end
  end

  // R5: a turnaround wait only ever follows a read
  p_turn_after_read_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_TURN) |-> lastRead);

endmodule

// File: rtl/nand_strobe_dpath.sv
module nand_strobe_dpath
  import nand_strobe_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           ss,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  accCnt,
  input  logic [DATA_W-1:0] dqIn,
  output logic              reN,
  output logic              weN,
  output logic [DATA_W-1:0] dqOut,
  output logic              dqOe,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);
  localparam int MASK_W = (1 << CNT_W) - 1;

  // bit i set: sample the bus i+1 edges from now
  logic [MASK_W-1:0] capMask, capNext, capArm;

  always_comb begin
    capArm  = ss.fallRd ? (MASK_W'(1) << (accCnt - CNT_W'(1))) : '0;
    capNext = (capMask >> 1) | capArm;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reN     <= 1'b1;
      weN     <= 1'b1;
      dqOut   <= '0;
      dqOe    <= 1'b0;
      capMask <= '0;
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      if (ss.loadWr) dqOut <= wdata;
      if (ss.rise) begin
        reN <= 1'b1;
        weN <= 1'b1;
      end
      if (ss.endCycle) dqOe <= 1'b0;
      if (ss.fallRd) reN <= 1'b0;
      if (ss.fallWr) begin
        weN  <= 1'b0;
        dqOe <= 1'b1;
      end
      capMask <= capNext;
      rdValid <= capMask[0];
      if (capMask[0]) rdData <= dqIn;
    end
  end

  // R1: a new strobe only starts when both strobes are idle high
  p_fall_from_high_r1: assert property (@(posedge clk) disable iff (!rstN)
    (ss.fallRd || ss.fallWr) |-> (reN && weN));

  // R4: with a static setup, reads are two or more cycles apart, so valid never repeats
  p_single_valid_r4: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);

endmodule

// File: rtl/nand_strobe_gen.sv
module nand_strobe_gen
  import nand_strobe_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CFG_W  = 6,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [CFG_W-1:0]  cfgLo,
  input  logic [CFG_W-1:0]  cfgHi,
  input  logic [CFG_W-1:0]  cfgAcc,
  input  logic [CFG_W-1:0]  cfgTurn,
  input  logic [DATA_W-1:0] dqIn,
  output logic              busy,
  output logic              reN,
  output logic              weN,
  output logic [DATA_W-1:0] dqOut,
  output logic              dqOe,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);
  localparam int NUM_FIELDS = 4;
  localparam int RUN_W      = CNT_W + 1;
  localparam logic [RUN_W-1:0] RUN_MAX = '1;

  logic [NUM_FIELDS-1:0][CFG_W-1:0] rawCfg;
  logic [NUM_FIELDS-1:0][CNT_W-1:0] effCfg;
  logic [CNT_W-1:0] loCnt, hiCnt, accCnt, turnCnt;
  strobe_t ss;

  assign rawCfg = {cfgTurn, cfgAcc, cfgHi, cfgLo};

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_clamp
    nand_cnt_clamp #(.IN_W(CFG_W), .OUT_W(CNT_W)) i_clamp (
      .raw (rawCfg[g]),
      .eff (effCfg[g])
    );
  end

  assign loCnt   = effCfg[0];
  assign hiCnt   = effCfg[1];
  assign accCnt  = effCfg[2];
  assign turnCnt = effCfg[3];

  nand_strobe_ctrl #(.CNT_W(CNT_W)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .loCnt    (loCnt),
    .hiCnt    (hiCnt),
    .turnCnt  (turnCnt),
    .busy     (busy),
    .ss       (ss)
  );

  nand_strobe_dpath #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .ss      (ss),
    .wdata   (reqWdata),
    .accCnt  (accCnt),
    .dqIn    (dqIn),
    .reN     (reN),
    .weN     (weN),
    .dqOut   (dqOut),
    .dqOe    (dqOe),
    .rdData  (rdData),
    .rdValid (rdValid)
  );

  // port-level observers for the assertions below
  logic [RUN_W-1:0] lowRun, reHighAge;
  logic             lastWasRd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowRun    <= '0;
      reHighAge <= RUN_MAX;
      lastWasRd <= 1'b0;
    end else begin
      if (!reN || !weN) lowRun <= (lowRun == RUN_MAX) ? lowRun : lowRun + RUN_W'(1);
      else              lowRun <= '0;
      if (!reN) reHighAge <= '0;
      else if (reHighAge != RUN_MAX) reHighAge <= reHighAge + RUN_W'(1);
      if (!reN)      lastWasRd <= 1'b1;
      else if (!weN) lastWasRd <= 1'b0;
    end
  end

  p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(!reN && !weN));

  p_low_width_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reN && weN) |-> (lowRun == RUN_W'(loCnt)));

  p_turn_gap_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(weN) && lastWasRd) |-> (reHighAge >= RUN_W'(turnCnt)));

  p_busy_while_low_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!reN || !weN) |-> busy);

endmodule

// File: tb/test_nand_strobe_gen.sv
module test_nand_strobe_gen;
  localparam int DATA_W = 8;
  localparam int CFG_W  = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [DATA_W-1:0] reqWdata = '0;
  logic [CFG_W-1:0] cfgLo = '0, cfgHi = '0, cfgAcc = '0, cfgTurn = '0;
  logic [DATA_W-1:0] dqIn;
  logic busy, reN, weN, dqOe, rdValid;
  logic [DATA_W-1:0] dqOut, rdData;

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;
  assign dqIn = cyc[DATA_W-1:0];  // sampled word names its edge

  nand_strobe_gen #(.DATA_W(DATA_W), .CFG_W(CFG_W)) i_nand_strobe_gen (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqWdata(reqWdata), .cfgLo(cfgLo), .cfgHi(cfgHi), .cfgAcc(cfgAcc),
    .cfgTurn(cfgTurn), .dqIn(dqIn), .busy(busy), .reN(reN), .weN(weN),
    .dqOut(dqOut), .dqOe(dqOe), .rdData(rdData), .rdValid(rdValid)
  );

  int checks = 0, fails = 0;
  int expLo = 1, expHi = 1, expAcc = 1, expGap = -1;
  bit periodChk = 0;
  int fallCount = 0, rdCount = 0, lastLowRun = 0;
  int lastFallCyc = -1, lastRiseCyc = 0;
  bit riseWasRead = 0;

  bit  wrQ[$];
  byte dQ[$];
  int  capQ[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int sat(input int v);
    if (v == 0) return 1;
    if (v > 15) return 15;
    return v;
  endfunction

  task automatic setCfg(input int lo, input int hi, input int acc, input int turn);
    cfgLo = CFG_W'(lo); cfgHi = CFG_W'(hi); cfgAcc = CFG_W'(acc); cfgTurn = CFG_W'(turn);
    expLo = sat(lo); expHi = sat(hi); expAcc = sat(acc);
  endtask

  // driver: called at a negedge, returns at the negedge after acceptance
  task automatic issue(input bit wr, input byte d);
    while (busy) @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqWdata = d;
    wrQ.push_back(wr);
    dQ.push_back(d);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic waitIdle();
    repeat (60) @(negedge clk);
  endtask

  // monitor / scoreboard
  bit prevRe = 1, prevWe = 1;
  int lowRun = 0;
  always @(negedge clk) begin
    if (!rstN) begin
      prevRe = 1; prevWe = 1; lowRun = 0;
    end else begin
      if ((reN && !prevRe) || (weN && !prevWe)) begin
        check(lowRun == expLo, "R2 strobe low width", lowRun, expLo);
        lastLowRun = lowRun;
        lastRiseCyc = cyc;
        riseWasRead = reN && !prevRe;
      end
      if ((!reN && prevRe) || (!weN && prevWe)) begin
        fallCount++;
        if (wrQ.size() == 0) begin
          check(0, "R1 strobe fall without accepted request", 1, 0);
        end else begin
          bit  wr;
          byte d;
          wr = wrQ.pop_front();
          d  = dQ.pop_front();
          check(wr == (!weN && prevWe), "R1 strobe direction", int'(!weN), int'(wr));
          if (!wr) capQ.push_back((cyc - 1 + expAcc) & 255);
          else begin
            check(dqOe && dqOut == d, "R8 write word on bus", int'(dqOut), int'(d));
            if (expGap >= 0 && riseWasRead)
              check(cyc - lastRiseCyc == expGap, "R5 turnaround gap", cyc - lastRiseCyc, expGap);
          end
        end
        if (periodChk && lastFallCyc >= 0)
          check(cyc - lastFallCyc == expLo + expHi, "R3 back-to-back period",
                cyc - lastFallCyc, expLo + expHi);
        lastFallCyc = cyc;
      end
      if (!reN || !weN) lowRun++; else lowRun = 0;
      if (rdValid) begin
        rdCount++;
        if (capQ.size() == 0) check(0, "R10 capture without read", 1, 0);
        else begin
          int e;
          e = capQ.pop_front();
          check(int'(rdData) == e, "R4 captured word", int'(rdData), e);
        end
      end
      prevRe = reN; prevWe = weN;
    end
  end

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual 1 expected 0");
    finishRun();
  end

  initial begin
    int base;
    setCfg(3, 2, 2, 1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    check(reN && weN && !busy && !rdValid && !dqOe, "R9 reset state",
          {reN, weN, busy, rdValid, dqOe}, 5'b11000);
    rstN = 1'b1;
    @(negedge clk);
    check(reN && weN && !busy && !dqOe, "R9 idle after reset", {reN, weN, busy, dqOe}, 4'b1100);

    // R4: sample before the strobe rises
    base = rdCount;
    issue(0, 0); waitIdle();
    check(rdCount == base + 1, "R4 one capture per read", rdCount - base, 1);

    // R4: sample after the strobe has risen
    setCfg(3, 2, 5, 1);
    base = rdCount;
    issue(0, 0); waitIdle();
    check(rdCount == base + 1, "R4 late capture", rdCount - base, 1);

    // R3/R4: back-to-back reads, capture past the next fall
    setCfg(2, 1, 6, 1);
    periodChk = 1; lastFallCyc = -1;
    base = rdCount;
    for (int i = 0; i < 4; i++) issue(0, 0);
    waitIdle();
    periodChk = 0;
    check(rdCount == base + 4, "R4 overlapping captures", rdCount - base, 4);

    // R8/R10: writes
    setCfg(2, 2, 3, 1);
    base = rdCount;
    issue(1, 8'hA5);
    issue(1, 8'h3C);
    waitIdle();
    check(rdCount == base, "R10 no capture on writes", rdCount - base, 0);
    check(!dqOe, "R8 bus released when idle", int'(dqOe), 0);

    // R5: turnaround inserted
    setCfg(2, 1, 1, 5);
    expGap = 5;
    issue(0, 0); issue(1, 8'h5A); waitIdle();
    // R5: high time already covers the turnaround
    setCfg(2, 6, 1, 3);
    expGap = 6;
    issue(0, 0); issue(1, 8'hC3); waitIdle();
    expGap = -1;

    // R6: saturation
    setCfg(50, 40, 63, 1);
    base = rdCount;
    issue(0, 0); waitIdle();
    check(lastLowRun == 15, "R6 low count saturates", lastLowRun, 15);
    check(rdCount == base + 1, "R6 capture at saturated delay", rdCount - base, 1);

    // R7: zeros act as one
    setCfg(0, 0, 0, 0);
    periodChk = 1; lastFallCyc = -1;
    for (int i = 0; i < 3; i++) issue(0, 0);
    waitIdle();
    periodChk = 0;
    check(lastLowRun == 1, "R7 zero low count", lastLowRun, 1);

    // R1: request during busy is ignored
    setCfg(8, 2, 2, 1);
    base = fallCount;
    issue(0, 0);
    repeat (2) @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    waitIdle();
    check(fallCount == base + 1, "R1 busy request ignored", fallCount - base, 1);
    check(wrQ.size() == 0 && capQ.size() == 0, "R1 scoreboard drained",
          wrQ.size() + capQ.size(), 0);

    finishRun();
  end
endmodule